// File: doc/BRIEF.md
# If-Then Condition Tracker

This block decides whether an instruction that trapped would really have executed under the current condition flags. It also produces the processor state that follows when the instruction is skipped.

The condition code comes from one of two sources:
- When the trap syndrome marks its condition field as valid, the code is taken from the syndrome.
- Otherwise it comes from the packed if-then block state. That state is split across two fields of the status word.

On a skip strobe the block registers two results:
- an updated status word, in which the if-then state has moved on by one slot;
- a new program counter, stepped by the size of the skipped instruction.

An exception handler uses the pass result to decide between emulating the instruction and stepping over it. It uses the registered outputs to resume the interrupted stream.

Top module: `it_cond_tracker`

## Requirements
- R1: After a synchronous active-high reset, `status_o` and `pc_o` read zero and `upd_valid_o` is low.
- R2: If either syndrome bit 31 or bit 30 is set, `pass_o` is 1 whatever the flags and the other fields.
- R3: If syndrome bits [31:30] are zero and syndrome bit 24 (condition valid) is set, the condition code is syndrome bits [23:20]. It is tested against the flags N=status[31], Z=status[30], C=status[29] and V=status[28].
- R4: If syndrome bits [31:30] and bit 24 are all zero, the syndrome condition field is ignored. The 8-bit if-then state is built as IT[7:2]=status[15:10] and IT[1:0]=status[26:25]. An all-zero state passes, and a nonzero state uses IT[7:4] as the condition code.
- R5: Condition codes evaluate as follows:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
  - 14 and 15: always pass.
- R6: On a skip with IT[2:0] nonzero, the new state keeps IT[7:5]. Its IT[4:0] becomes the old IT[3:0] followed by a 0 bit, and it is written back into the same status-word fields.
- R7: On a skip with IT[2:0] zero, the whole if-then state in the updated status word is cleared.
- R8: On a skip, `pc_o` is `pc_i`+2 when the compact-instruction bit status[5] is set and `wide_i` is 0. Otherwise it is `pc_i`+4.
- R9: `it_err_o` is 1 exactly when status[5] is clear and the if-then state is nonzero.
- R10: The cycle after a skip strobe, `upd_valid_o` is high for one cycle, and every status bit outside the if-then fields equals the input. With no strobe, `status_o` and `pc_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_i | input | 32 | Status word: flags, compact bit, if-then fields |
| syndrome_i | input | 32 | Trap syndrome word |
| pc_i | input | PC_W | Program counter of the trapped instruction |
| wide_i | input | 1 | Trapped instruction is the 32-bit form |
| skip_i | input | 1 | Strobe: skip the instruction and advance the state |
| pass_o | output | 1 | Instruction would have executed |
| it_err_o | output | 1 | If-then state nonzero outside compact mode |
| upd_valid_o | output | 1 | Registered results were loaded on the last edge |
| status_o | output | 32 | Updated status word |
| pc_o | output | PC_W | Next program counter |

## Verification
The bench uses an if-then state whose only nonzero bits are IT[1:0]. A design that forgot the upper status field would call that state unconditional and report a pass.

It puts an always-pass code in the syndrome field while the valid bit is clear. A design that read the syndrome field regardless would pass where the if-then condition fails.

It runs the advance on a state whose low three bits are zero and on one that has them set, with mixed upper bits. A wrong shift width or a missing clear shows up directly in the status word.

It also covers the signed and unsigned compare codes at their boundaries, and the narrow and wide step in both instruction modes. A swapped step size or a misplaced flag bit fails there.

// File: rtl/it_cond_pkg.sv
package it_cond_pkg;

  localparam int SW_W        = 32;
  localparam int FLAG_N      = 31;
  localparam int FLAG_Z      = 30;
  localparam int FLAG_C      = 29;
  localparam int FLAG_V      = 28;
  localparam int COMPACT_BIT = 5;
  localparam int ITH_LSB     = 10;  // IT[7:2]
  localparam int ITH_W       = 6;
  localparam int ITL_LSB     = 25;  // IT[1:0]
  localparam int ITL_W       = 2;
  localparam int IT_W        = ITH_W + ITL_W;
  localparam int SYN_CLS_LSB = 30;
  localparam int SYN_CV_BIT  = 24;
  localparam int SYN_CC_LSB  = 20;
  localparam int CC_W        = 4;
  localparam int STEP_NARROW = 2;
  localparam int STEP_WIDE   = 4;

  typedef enum logic [CC_W-1:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic [IT_W-1:0] it_unpack(input logic [SW_W-1:0] sw);
    return {sw[ITH_LSB +: ITH_W], sw[ITL_LSB +: ITL_W]};
  endfunction

  function automatic logic [SW_W-1:0] it_repack(input logic [SW_W-1:0] sw,
                                                input logic [IT_W-1:0] it);
    logic [SW_W-1:0] r;
    r = sw;
    r[ITH_LSB +: ITH_W] = it[IT_W-1:ITL_W];
    r[ITL_LSB +: ITL_W] = it[ITL_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/it_cond_select.sv
module it_cond_select
  import it_cond_pkg::*;
(
  input  logic [SW_W-1:0] status_i,
  input  logic [SW_W-1:0] syndrome_i,
  output cc_e             cc_o,
  output logic            uncond_o
);
  logic [IT_W-1:0] it_st;

  always_comb begin
    it_st    = it_unpack(status_i);
    cc_o     = CC_AL;
    uncond_o = 1'b0;
    if (syndrome_i[SYN_CLS_LSB +: 2] != 2'b00) begin
      uncond_o = 1'b1;
    end else if (syndrome_i[SYN_CV_BIT]) begin
      cc_o = cc_e'(syndrome_i[SYN_CC_LSB +: CC_W]);
    end else if (it_st == '0) begin
      uncond_o = 1'b1;
    end else begin
      cc_o = cc_e'(it_st[IT_W-1 -: CC_W]);
    end
  end
endmodule

// File: rtl/it_cond_eval.sv
module it_cond_eval
  import it_cond_pkg::*;
(
  input  cc_e   cc_i,
  input  nzcv_t flags_i,
  output logic  pass_o
);
  logic sgn_eq;

  always_comb begin
    sgn_eq = (flags_i.n == flags_i.v);
    unique case (cc_i)
      CC_EQ: pass_o = flags_i.z;
      CC_NE: pass_o = !flags_i.z;
      CC_CS: pass_o = flags_i.c;
      CC_CC: pass_o = !flags_i.c;
      CC_MI: pass_o = flags_i.n;
      CC_PL: pass_o = !flags_i.n;
      CC_VS: pass_o = flags_i.v;
      CC_VC: pass_o = !flags_i.v;
      CC_HI: pass_o = flags_i.c && !flags_i.z;
      CC_LS: pass_o = !flags_i.c || flags_i.z;
      CC_GE: pass_o = sgn_eq;
      CC_LT: pass_o = !sgn_eq;
      CC_GT: pass_o = !flags_i.z && sgn_eq;
      CC_LE: pass_o = flags_i.z || !sgn_eq;
      default: pass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/it_advance.sv
module it_advance
  import it_cond_pkg::*;
(
  input  logic [SW_W-1:0] status_i,
  output logic [SW_W-1:0] status_o,
  output logic            it_nz_o
);
  logic [IT_W-1:0] cur_it;
  logic [IT_W-1:0] nxt_it;

  always_comb begin
    cur_it  = it_unpack(status_i);
    it_nz_o = (cur_it != '0);
    if (cur_it[2:0] == 3'b000)
      nxt_it = '0;
    else
      nxt_it = {cur_it[IT_W-1:5], cur_it[3:0], 1'b0};
    status_o = it_repack(status_i, nxt_it);
  end
endmodule

// File: rtl/it_cond_tracker.sv
module it_cond_tracker
  import it_cond_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW_W-1:0] status_i,
  input  logic [SW_W-1:0] syndrome_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            wide_i,
  input  logic            skip_i,
  output logic            pass_o,
  output logic            it_err_o,
  output logic            upd_valid_o,
  output logic [SW_W-1:0] status_o,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [SW_W-1:0] IT_MASK =
    ({{(SW_W-ITH_W){1'b0}}, {ITH_W{1'b1}}} << ITH_LSB) |
    ({{(SW_W-ITL_W){1'b0}}, {ITL_W{1'b1}}} << ITL_LSB);

  cc_e             sel_cc;
  logic            sel_uncond;
  logic            cc_pass;
  logic [SW_W-1:0] adv_status;
  logic            it_nz;
  logic            compact;
  logic [PC_W-1:0] pc_step;
  nzcv_t           flags;

  assign flags   = '{n: status_i[FLAG_N], z: status_i[FLAG_Z],
                     c: status_i[FLAG_C], v: status_i[FLAG_V]};
  assign compact = status_i[COMPACT_BIT];

  it_cond_select u_sel (
    .status_i   (status_i),
    .syndrome_i (syndrome_i),
    .cc_o       (sel_cc),
    .uncond_o   (sel_uncond)
  );

  it_cond_eval u_eval (
    .cc_i    (sel_cc),
    .flags_i (flags),
    .pass_o  (cc_pass)
  );

  it_advance u_adv (
    .status_i (status_i),
    .status_o (adv_status),
    .it_nz_o  (it_nz)
  );

  assign pass_o   = sel_uncond || cc_pass;
  assign it_err_o = !compact && it_nz;
  assign pc_step  = (compact && !wide_i) ? PC_W'(STEP_NARROW) : PC_W'(STEP_WIDE);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o    <= '0;
      pc_o        <= '0;
      upd_valid_o <= 1'b0;
    end else begin
      upd_valid_o <= skip_i;
      if (skip_i) begin
        status_o <= adv_status;
        pc_o     <= pc_i + pc_step;
      end
    end
  end

  p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
    upd_valid_o |-> ((pc_o - $past(pc_i)) == PC_W'(STEP_NARROW) ||
                     (pc_o - $past(pc_i)) == PC_W'(STEP_WIDE)));

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    upd_valid_o |-> $past(skip_i));

  p_other_bits_kept_r10: assert property (@(posedge clk) disable iff (rst)
    upd_valid_o |-> ((status_o & ~IT_MASK) == ($past(status_i) & ~IT_MASK)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(skip_i) |-> ($stable(status_o) && $stable(pc_o)));

  p_it_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    (skip_i && status_i[ITL_LSB +: ITL_W] == 2'b00 && status_i[ITH_LSB] == 1'b0)
      |=> ((status_o & IT_MASK) == '0));

  p_uncond_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (syndrome_i[SYN_CLS_LSB +: 2] != 2'b00) |-> pass_o);
endmodule

// File: tb/it_cond_tracker_tb.sv
`timescale 1ns/1ps
module it_cond_tracker_tb;
  localparam int PC_W = 32;
  localparam int NV   = 20;

  logic            clk = 1'b0;
  logic            rst;
  logic [31:0]     status_i, syndrome_i;
  logic [PC_W-1:0] pc_i;
  logic            wide_i, skip_i;
  logic            pass_o, it_err_o, upd_valid_o;
  logic [31:0]     status_o;
  logic [PC_W-1:0] pc_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  it_cond_tracker #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst(rst), .status_i(status_i), .syndrome_i(syndrome_i),
    .pc_i(pc_i), .wide_i(wide_i), .skip_i(skip_i), .pass_o(pass_o),
    .it_err_o(it_err_o), .upd_valid_o(upd_valid_o), .status_o(status_o),
    .pc_o(pc_o)
  );

  // {status, syndrome, expected pass}
  localparam logic [64:0] VEC [NV] = '{
    {32'h0000_0000, 32'hC000_0000, 1'b1},  // R2 class bits set
    {32'h4000_0000, 32'h0100_0000, 1'b1},  // R3 EQ, Z set
    {32'h0000_0000, 32'h0100_0000, 1'b0},  // R3 EQ, Z clear
    {32'h0000_0000, 32'h0110_0000, 1'b1},  // R5 NE
    {32'h2000_0000, 32'h0120_0000, 1'b1},  // R5 CS
    {32'h6000_0000, 32'h0180_0000, 1'b0},  // R5 HI with Z
    {32'h9000_0000, 32'h01A0_0000, 1'b1},  // R5 GE N=V=1
    {32'h8000_0000, 32'h01B0_0000, 1'b1},  // R5 LT N!=V
    {32'hD000_0000, 32'h01C0_0000, 1'b0},  // R5 GT with Z
    {32'h0000_0000, 32'h01D0_0000, 1'b0},  // R5 LE false
    {32'h0000_0000, 32'h01E0_0000, 1'b1},  // R5 AL
    {32'h0000_0000, 32'h01F0_0000, 1'b1},  // R5 code 15
    {32'h1000_0000, 32'h0160_0000, 1'b1},  // R5 VS
    {32'h0000_0000, 32'h0140_0000, 1'b0},  // R5 MI false
    {32'h0000_0020, 32'h0000_0000, 1'b1},  // R4 IT zero
    {32'h0000_0820, 32'h0000_0000, 1'b0},  // R4 IT=0x08 EQ, Z clear
    {32'h4000_0820, 32'h0000_0000, 1'b1},  // R4 IT=0x08 EQ, Z set
    {32'h4000_1820, 32'h00E0_0000, 1'b0},  // R4 NE from IT, syndrome AL ignored
    {32'h0200_4020, 32'h0000_0000, 1'b0},  // R4 IT=0x41 MI false
    {32'h0400_0020, 32'h0000_0000, 1'b0}   // R4 IT=0x02 only low field
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_skip(input logic [31:0] st, input logic [31:0] pc, input logic wd);
    @(negedge clk);
    status_i = st; pc_i = pc; wide_i = wd; syndrome_i = '0; skip_i = 1'b1;
    @(negedge clk);
    skip_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; status_i = '0; syndrome_i = '0; pc_i = '0; wide_i = 1'b0; skip_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(status_o, 32'h0, "R1 status reset");
    chk(pc_o, 32'h0, "R1 pc reset");
    chk({31'h0, upd_valid_o}, 32'h0, "R1 valid reset");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      status_i   = VEC[i][64:33];
      syndrome_i = VEC[i][32:1];
      #1;
      chk({31'h0, pass_o}, {31'h0, VEC[i][0]}, $sformatf("R2-R5 vector %0d", i));
    end

    // R8 / R10: no compact mode, narrow flag ignored
    do_skip(32'hF000_0000, 32'h0000_1000, 1'b0);
    chk(pc_o, 32'h0000_1004, "R8 step without compact");
    chk(status_o, 32'hF000_0000, "R10 status passthrough");
    chk({31'h0, upd_valid_o}, 32'h1, "R10 valid pulse");

    do_skip(32'h0000_0020, 32'h0000_2000, 1'b0);
    chk(pc_o, 32'h0000_2002, "R8 compact narrow");
    do_skip(32'h0000_0020, 32'h0000_2000, 1'b1);
    chk(pc_o, 32'h0000_2004, "R8 compact wide");

    // R7: IT=0x18 has low three bits zero
    do_skip(32'hA000_1820, 32'h0000_0100, 1'b1);
    chk(status_o, 32'hA000_0020, "R7 state cleared");

    // R6: IT=0x6B advances to 0x76
    do_skip(32'h5600_683F, 32'h0000_3000, 1'b0);
    chk(status_o, 32'h5400_743F, "R6 advance shift");
    chk(pc_o, 32'h0000_3002, "R6 pc with advance");

    @(negedge clk);
    chk({31'h0, upd_valid_o}, 32'h0, "R10 valid drops");
    chk(status_o, 32'h5400_743F, "R10 status held");

    // R9
    status_i = 32'h0000_0800; #1;
    chk({31'h0, it_err_o}, 32'h1, "R9 error outside compact");
    status_i = 32'h0000_0820; #1;
    chk({31'h0, it_err_o}, 32'h0, "R9 no error in compact");
    status_i = 32'h0000_0000; #1;
    chk({31'h0, it_err_o}, 32'h0, "R9 no error zero state");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule